// File: doc/BRIEF.md
# I2C Indexed Block-Access Register Target

This block is a target-only I2C device that holds a small control register file for a clock fan-out stage. A host writes a run of registers by sending the device write address, then a starting register offset, then a byte count, and then that many data bytes. The data bytes land in consecutive registers. A host reads by first setting the offset with a write-address phase. It then issues a repeated START and the read address. The target answers with a byte count followed by consecutive register contents until the host refuses a byte.

The bus lines are sampled in the system clock domain through synchronisers. START and STOP are taken from SDA edges seen while SCL is high, and either one cancels whatever transfer is under way. The target never drives SDA high. It only asserts an open-drain pull-down enable, which the pad logic turns into a low level on the wire. Register 0 carries four output-enable bits, which come out of the block as plain level pins. Register 6 is a fixed identification byte.

Top module: `i2creg_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), formed from the 7-bit address 0x69 and a direction bit in bit 0. Any other address byte is not acknowledged, and every byte after it is also ignored and not acknowledged until the next START.
- R2: In a write transfer the byte after 0xD2 sets the register pointer and the next byte sets the byte count, and both are acknowledged. Each accepted data byte is then written to the register at the pointer, and the pointer then advances by one.
- R3: In a write transfer, data bytes beyond the byte count are not acknowledged and are not written. A count of 0 means that no data byte is accepted.
- R4: Bits 3:0 of register 0 drive oe_out[3:0] and reset to 1 (1 = enabled). Bit 3 is output 5 and bit 0 is output 8. Bits 7:4 of register 0 read as 0.
- R5: Register 6 always reads 0x01, with revision ID 0 in bits 7:4 and vendor ID 1 in bits 3:0. Writes to register 6 are acknowledged within the count but change nothing.
- R6: Registers 1 to 5 and every offset of 7 or more read as 0. Writes to them are acknowledged within the count but change nothing.
- R7: After 0xD3 is acknowledged, the target first sends a count equal to 7 minus the pointer (0 when the pointer is 7 or more). It then sends the register at the pointer, advancing the pointer after every data byte. It continues while the host acknowledges and releases the bus after a host NACK.
- R8: The pointer keeps its value across a repeated START and across a STOP. A read that goes straight to 0xD3 uses the pointer left by the previous transfer.
- R9: A START or STOP at any point ends the current transfer at once. A partly shifted byte is discarded and no register is changed by it. A START is always followed by address reception.
- R10: SDA is only ever pulled low through sda_oe. sda_oe changes only while the synchronised SCL is low, and it is released after reset, after a STOP and while the bus is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| oe_out | output | 4 | Output-enable levels from register 0 bits 3:0 |

## Verification
The hardest states to reach from the pins are the ones where a transfer is cut short. Examples are a START or STOP landing after only half a data byte has been shifted, and a read that relies on a pointer left behind by an earlier aborted or write-only transfer. The bench drives a bit-level host that can stop after any number of bits. It then issues STOP or a repeated START and reads straight from 0xD3, so the surviving pointer and the unchanged enables become visible in the returned count and data. Count overruns, a wrong address followed by a byte that looks like a valid address, and random offset/count/length mixes checked against a bench register model cover the rest.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_WCNT,
    ST_WDATA,
    ST_RCNT,
    ST_RDATA
  } tgt_state_e;
endpackage

// File: rtl/i2creg_line_sync.sv
module i2creg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             scl_p, sda_p;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh[STAGES-1];
  end

  assign scl_q = synced[1];
  assign sda_q = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2creg_file.sv
module i2creg_file #(
  parameter int          OE_BITS  = 4,
  parameter int          ID_INDEX = 6,
  parameter logic [7:0]  ID_VALUE = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic [OE_BITS-1:0] oe_out
);
  localparam logic [7:0] ID_ADDR = 8'(ID_INDEX);

  logic [OE_BITS-1:0] oe_q;
  logic               unused_hi;

  assign unused_hi = ^wr_data[7:OE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          oe_q <= '1;
    else if (wr_en && wr_addr == 8'd0)   oe_q <= wr_data[OE_BITS-1:0];
  end

  always_comb begin
    rd_data = 8'd0;
    if (rd_addr == 8'd0)         rd_data[OE_BITS-1:0] = oe_q;
    else if (rd_addr == ID_ADDR) rd_data = ID_VALUE;
  end

  assign oe_out = oe_q;
endmodule

// File: rtl/i2creg_engine.sv
module i2creg_engine
  import i2creg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  output tgt_state_e state
);
  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};
  localparam logic [7:0] NREG8   = 8'(NUM_REGS);

  tgt_state_e nxt;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, txreg, ptr, remain, blk_cnt;
  logic       mack;

  assign blk_cnt = (ptr < NREG8) ? (NREG8 - ptr) : 8'd0;
  assign rd_addr = ptr + {7'd0, state == ST_RDATA};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; nxt <= ST_IDLE; bit_cnt <= '0;
      shreg <= '0; txreg <= '0; ptr <= '0; remain <= '0;
      mack <= 1'b1; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; bit_cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; bit_cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: ;
          ST_RCNT, ST_RDATA: begin
            if (scl_rise && bit_cnt == 4'd8) mack <= sda_q;
            if (scl_fall) begin
              if (bit_cnt < 4'd8) begin
                bit_cnt <= bit_cnt + 4'd1;
                txreg   <= {txreg[6:0], 1'b0};
                sda_oe  <= (bit_cnt == 4'd7) ? 1'b0 : ~txreg[6];
              end else begin
                bit_cnt <= '0;
                if (state == ST_RDATA) ptr <= ptr + 8'd1;
                if (!mack) begin
                  state <= ST_RDATA; txreg <= rd_data; sda_oe <= ~rd_data[7];
                end else begin
                  state <= ST_IDLE; sda_oe <= 1'b0;
                end
              end
            end
          end
          default: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= 4'd9;
              case (state)
                ST_ADDR: begin
                  if (shreg == WR_BYTE)      begin sda_oe <= 1'b1; nxt <= ST_OFFS; end
                  else if (shreg == RD_BYTE) begin sda_oe <= 1'b1; nxt <= ST_RCNT; end
                  else                       state <= ST_IDLE;
                end
                ST_OFFS: begin sda_oe <= 1'b1; ptr <= shreg;    nxt <= ST_WCNT;  end
                ST_WCNT: begin sda_oe <= 1'b1; remain <= shreg; nxt <= ST_WDATA; end
                default: begin
                  nxt <= ST_WDATA;
                  if (remain != 8'd0) begin
                    sda_oe  <= 1'b1;
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                    ptr     <= ptr + 8'd1;
                    remain  <= remain - 8'd1;
                  end
                end
              endcase
            end else if (scl_fall && bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              state   <= nxt;
              if (nxt == ST_RCNT) begin
                txreg  <= blk_cnt;
                sda_oe <= ~blk_cnt[7];
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2creg_target.sv
module i2creg_target
  import i2creg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 7,
  parameter int         OE_BITS     = 4,
  parameter int         ID_INDEX    = 6,
  parameter logic [7:0] ID_VALUE    = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [OE_BITS-1:0] oe_out
);
  logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  tgt_state_e state;

  i2creg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_in, .sda_in,
    .scl_q, .sda_q, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2creg_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk, .rst_n, .sda_q, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_data, .sda_oe, .wr_en, .wr_addr, .wr_data, .rd_addr, .state
  );

  i2creg_file #(.OE_BITS(OE_BITS), .ID_INDEX(ID_INDEX), .ID_VALUE(ID_VALUE)) u_file (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .oe_out
  );
endmodule

// File: rtl/i2creg_target_chk.sv
module i2creg_target_chk
  import i2creg_pkg::*;
#(
  parameter int         OE_BITS  = 4,
  parameter int         ID_INDEX = 6,
  parameter logic [7:0] ID_VALUE = 8'h01
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic [OE_BITS-1:0] oe_out,
  input logic               scl_q,
  input logic               start_det,
  input logic               stop_det,
  input tgt_state_e         state,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic [7:0]         rd_addr,
  input logic [7:0]         rd_data
);
  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q); // R10

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R1

  AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_out) |-> $past(wr_en && wr_addr == 8'd0)); // R2

  AST_ID_READ_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'(ID_INDEX)) |-> (rd_data == ID_VALUE)); // R5

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR)); // R9

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe)); // R9
endmodule

bind i2creg_target i2creg_target_chk #(
  .OE_BITS(OE_BITS), .ID_INDEX(ID_INDEX), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk, .rst_n, .sda_oe, .oe_out, .scl_q, .start_det, .stop_det,
  .state, .wr_en, .wr_addr, .rd_addr, .rd_data
);

// File: tb/i2creg_target_tb_top.sv
module i2creg_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire        sda_oe;
  wire  [3:0] oe_out;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] m_oe  = 4'hF;
  logic [7:0] m_ptr = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2creg_target dut_i (
    .clk, .rst_n, .scl_in(scl_m), .sda_in(sda_line), .sda_oe, .oe_out
  );

  function automatic logic [7:0] exp_reg(input logic [7:0] a);
    if (a == 8'd0) return {4'd0, m_oe};
    if (a == 8'd6) return 8'h01;
    return 8'd0;
  endfunction

  function automatic logic [7:0] exp_cnt(input logic [7:0] p);
    return (p < 8'd7) ? 8'd7 - p : 8'd0;
  endfunction

  function automatic string reg_tag(input logic [7:0] a);
    if (a == 8'd0) return "R4";
    if (a == 8'd6) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = v[7-i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    send_bits(v, 8);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q/2); nack = sda_line; w(Q/2); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic nack);
    v = 8'd0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1'b1; w(Q/2); v = {v[6:0], sda_line}; w(Q/2); scl_m = 1'b0;
    end
    w(Q); sda_m = nack; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(1); sda_m = 1'b1; w(Q-1);
  endtask

  // after a START: read address, count, nb data bytes, STOP
  task automatic rd_body(input int nb, input string cnt_tag);
    logic nk;
    logic [7:0] v;
    send_byte(8'hD3, nk);
    check("R1 read address ack", nk, 1'b0);
    recv_byte(v, 1'b0);
    check({cnt_tag, " count byte"}, v, exp_cnt(m_ptr));
    for (int i = 0; i < nb; i++) begin
      recv_byte(v, i == nb - 1);
      check({"R7 ", reg_tag(m_ptr), " read data"}, v, exp_reg(m_ptr));
      m_ptr = m_ptr + 8'd1;
    end
    bus_stop();
    check("R10 released after stop", sda_oe, 1'b0);
  endtask

  task automatic rd_xfer(input bit use_off, input logic [7:0] off, input int nb);
    logic nk;
    bus_start();
    if (use_off) begin
      send_byte(8'hD2, nk); check("R1 write address ack", nk, 1'b0);
      send_byte(off, nk);   check("R2 offset ack", nk, 1'b0);
      m_ptr = off;
      bus_start();
    end
    rd_body(nb, use_off ? "R7" : "R8");
  endtask

  task automatic wr_xfer(input logic [7:0] off, input logic [7:0] cnt, input int nb,
                         input logic [63:0] dat);
    logic nk;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, nk); check("R1 write address ack", nk, 1'b0);
    send_byte(off, nk);   check("R2 offset ack", nk, 1'b0);
    send_byte(cnt, nk);   check("R2 count ack", nk, 1'b0);
    m_ptr = off;
    for (int i = 0; i < nb; i++) begin
      d = dat[8*i +: 8];
      send_byte(d, nk);
      check("R3 data ack within count", nk, (i >= int'(cnt)) ? 1'b1 : 1'b0);
      if (i < int'(cnt)) begin
        if (m_ptr == 8'd0) m_oe = d[3:0];
        m_ptr = m_ptr + 8'd1;
      end
    end
    bus_stop();
    check("R2 enables after write", oe_out, m_oe);
  endtask

  task automatic bad_addr();
    logic nk;
    logic [6:0] a;
    a = 7'($urandom);
    if (a == 7'h69) a = 7'h68;
    bus_start();
    send_byte({a, 1'($urandom)}, nk); check("R1 foreign address nack", nk, 1'b1);
    send_byte(8'hD2, nk);             check("R1 ignored until START", nk, 1'b1);
    send_byte(8'h00, nk);             check("R1 ignored until START", nk, 1'b1);
    bus_stop();
    check("R1 enables untouched", oe_out, m_oe);
  endtask

  initial begin
    logic nk;
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);
    w(5);
    check("R4 reset enables", oe_out, 4'hF);
    check("R10 reset release", sda_oe, 1'b0);
    rst_n = 1'b1;
    w(5);

    rd_xfer(1'b1, 8'd0, 7);                       // R7 full map
    wr_xfer(8'd0, 8'd1, 1, 64'h05);               // R4 enables
    rd_xfer(1'b1, 8'd0, 1);
    wr_xfer(8'd6, 8'd1, 1, 64'hA5);               // R5 read-only id
    rd_xfer(1'b1, 8'd6, 1);
    wr_xfer(8'd1, 8'd5, 5, 64'hFF_FF_FF_FF_FF);   // R6 reserved
    rd_xfer(1'b1, 8'd1, 5);
    wr_xfer(8'd0, 8'd0, 1, 64'h0A);               // R3 zero count
    wr_xfer(8'd0, 8'd1, 2, 64'h03_0C);            // R3 overrun
    rd_xfer(1'b1, 8'd7, 1);                       // R6 past the map
    rd_xfer(1'b1, 8'd200, 1);
    wr_xfer(8'd0, 8'd2, 2, 64'h00_09);            // R8 pointer left at 2
    rd_xfer(1'b0, 8'd0, 2);
    rd_xfer(1'b0, 8'd0, 3);
    bad_addr();
    rd_xfer(1'b0, 8'd0, 1);                       // R8 pointer survives R1 ignore

    // R9: STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD2, nk); send_byte(8'd0, nk); send_byte(8'd1, nk);
    m_ptr = 8'd0;
    send_bits(8'h60, 4);
    bus_stop();
    check("R9 stop mid-byte keeps enables", oe_out, m_oe);
    rd_xfer(1'b0, 8'd0, 1);

    // R9: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'hD2, nk); send_byte(8'd0, nk); send_byte(8'd2, nk);
    m_ptr = 8'd0;
    send_bits(8'hA0, 4);
    bus_start();
    rd_body(1, "R9");
    check("R9 start mid-byte keeps enables", oe_out, m_oe);

    for (int it = 0; it < 12; it++) begin
      logic [63:0] dat;
      dat = {$urandom, $urandom};
      wr_xfer(8'($urandom % 8), 8'($urandom % 5), int'($urandom % 5), dat);
      rd_xfer(1'b1, 8'($urandom % 8), 1 + int'($urandom % 3));
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule